// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block keeps a circular table of receive buffer descriptors in a small on-chip memory for one packet channel. Each packet arrives as a byte stream over a valid/ready interface. The first three bytes are the packet header and the rest is payload. For each packet the controller claims the current descriptor, but only when hardware owns it. It stores the payload through a byte-write port at the descriptor's buffer pointer and then closes the descriptor. Closing writes back the header bytes and the status bits. The controller may pulse an interrupt, and it then steps to the next descriptor.

Software sets up and inspects descriptors through a word-wide register port. Each descriptor is two 32-bit words:

- **Word 0:** bits [7:0] are control, bits [15:8] are header byte 0, bits [31:24] are header byte 1, and bits [23:16] are header byte 2.
- **Word 1:** the buffer pointer.
- **Register port address:** `{descriptor index, word select}`.

Error and header-check events go into a small event queue. Software drains that queue through a pop strobe.

Top module: `rx_bd_ring`

## Requirements
- R1: A packet is accepted only while control bit 0 (owned-by-hardware) of the current descriptor is 1. While that bit is 0, `in_ready` stays low and nothing is written to the buffer or the descriptor.
- R2: A packet closed without error and with control bit 1 (continuous) at 0 leaves word 0 with these contents:
  - bit 0 cleared and bit 7 (uncompleted) cleared;
  - bits 1–3 and 4–6 kept as they were;
  - header byte 0 in bits [15:8];
  - header bytes 1 and 2 in bits [31:24] and [23:16].
  Word 1 is never modified.
- R3: A packet closed without error and with control bit 1 at 1 leaves bit 0 at 1.
- R4: A receive error closes the descriptor with bit 0 cleared and bit 7 set, whatever bit 1 holds, and queues event code 1 with the configured channel id. A receive error is either `in_err` on any beat or a packet that ends before its third header byte.
- R5: Payload byte k is written to address buffer pointer + k, in arrival order.
- R6: After the descriptor with control bit 2 (wrap) at 1 closes, the next packet uses descriptor 0.
- R7: After the last table entry closes, the next packet uses descriptor 0 even when its bit 2 is 0. The last entry is the smaller of the table depth and 65536/8 entries.
- R8: `irq` pulses for exactly one cycle, in the cycle after the last beat is accepted. It pulses only when control bit 3 and `cfg_irq_en` are both 1.
- R9: A header whose three bytes do not XOR to zero queues event code 3 with channel id 0 when the third header byte is accepted. The packet is still stored and closed normally.
- R10: Payload bytes at offset `cfg_max_len` or beyond are not written. The descriptor closes with bit 0 cleared and bit 7 set. Event code 2 with the configured channel id is queued, unless a receive error takes precedence with code 1.
- R11: The event queue delivers entries in order. A push while it is full drops the entry and sets `evq_ovf`, which holds until channel init.
- R12: `chan_init` synchronously returns the controller to idle at descriptor 0 and empties the event queue, including `evq_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chan_init | input | 1 | Synchronous channel restart strobe |
| cfg_irq_en | input | 1 | Queue-level interrupt enable |
| cfg_cid | input | 8 | Channel id placed in error events |
| cfg_max_len | input | 16 | Largest payload stored per buffer |
| in_valid | input | 1 | Incoming byte valid |
| in_ready | output | 1 | Controller accepts the byte |
| in_data | input | 8 | Incoming byte |
| in_last | input | 1 | Byte ends the packet |
| in_err | input | 1 | Receive error seen with this byte |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| irq | output | 1 | Descriptor-serviced interrupt pulse |
| sw_we | input | 1 | Register port write strobe |
| sw_addr | input | IW+1 | Descriptor index and word select (bit 0) |
| sw_wdata | input | 32 | Register port write data |
| sw_rdata | output | 32 | Register port read data |
| evq_pop | input | 1 | Remove the head event |
| evq_valid | output | 1 | Event queue not empty |
| evq_code | output | 2 | Head event code |
| evq_cid | output | 8 | Head event channel id |
| evq_ovf | output | 1 | Sticky event drop flag |

## Verification
A wrong ring index shows up at the first packet that follows the faulty step. The bench rewrites only the descriptor it predicts, so the header lands in the wrong word or the channel stalls. A wrong ownership or error latch shows in word 0 three cycles after the last beat. A buffer-address slip shows on the first payload byte after it occurs. The event queue is drained after every packet, so a missing, extra or reordered event is reported before the next packet starts.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  // control bit positions inside word 0 (software depends on them)
  localparam int BIT_OWN  = 0;
  localparam int BIT_CONT = 1;
  localparam int BIT_WRAP = 2;
  localparam int BIT_INT  = 3;
  localparam int BIT_UNC  = 7;

  localparam int DESC_BYTES        = 8;
  localparam int TABLE_LIMIT_BYTES = 65536;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_RXERR = 2'd1,
    EV_TRUNC = 2'd2,
    EV_HDR   = 2'd3
  } ev_code_e;

  typedef struct packed {
    ev_code_e    code;
    logic [7:0]  cid;
  } ev_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HB1,
    ST_HB2,
    ST_PAY,
    ST_CLOSE
  } st_e;

  // header check: the three header bytes must XOR to zero
  function automatic logic hdr_good(input logic [7:0] a, input logic [7:0] b,
                                    input logic [7:0] c);
    return (a ^ b ^ c) == 8'h00;
  endfunction

  // closing value of word 0; ctl holds the old control bits [6:1]
  function automatic logic [31:0] close_word(input logic [7:0] h0,
                                             input logic [7:0] h1,
                                             input logic [7:0] h2,
                                             input logic [6:1] ctl,
                                             input logic bad);
    logic keep;
    keep = ctl[BIT_CONT] & ~bad;
    return {h1, h2, h0, bad, ctl[6:4], ctl[3:1], keep};
  endfunction
endpackage

// File: rtl/rxbd_table.sv
module rxbd_table #(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [IW:0]   sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic [IW-1:0] hw_idx,
  output logic [6:0]    hw_ctl,
  output logic [31:0]   hw_bufptr,
  input  logic          hw_we,
  input  logic [31:0]   hw_word0
);
  logic [31:0] word0 [DEPTH];
  logic [31:0] word1 [DEPTH];
  logic [IW-1:0] sw_idx;

  assign sw_idx = sw_addr[IW:1];

  // hardware close is written last, so it wins over a same-cycle software write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        word0[i] <= '0;
        word1[i] <= '0;
      end
    end else begin
      if (sw_we) begin
        if (sw_addr[0]) word1[sw_idx] <= sw_wdata;
        else            word0[sw_idx] <= sw_wdata;
      end
      if (hw_we) word0[hw_idx] <= hw_word0;
    end
  end

  assign sw_rdata  = sw_addr[0] ? word1[sw_idx] : word0[sw_idx];
  assign hw_ctl    = word0[hw_idx][6:0];
  assign hw_bufptr = word1[hw_idx];
endmodule

// File: rtl/rxbd_evq.sv
module rxbd_evq
  import rxbd_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  ev_t  push_ev,
  input  logic pop,
  output logic valid,
  output ev_t  head,
  output logic ovf
);
  ev_t           slots [DEPTH];
  logic [PW-1:0] rd_p, wr_p;
  logic [PW:0]   fill;
  logic          full, take, give;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (fill == (PW+1)'(DEPTH));
  assign valid = (fill != '0);
  assign take  = push & ~full;
  assign give  = pop & valid;
  assign head  = slots[rd_p];

  always_ff @(posedge clk) begin
    if (take) slots[wr_p] <= push_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rd_p <= '0;
      wr_p <= '0;
      fill <= '0;
      ovf  <= 1'b0;
    end else begin
      if (take) wr_p <= step(wr_p);
      if (give) rd_p <= step(rd_p);
      fill <= fill + (PW+1)'(take) - (PW+1)'(give);
      if (push && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine
  import rxbd_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int IW       = $clog2(DEPTH),
  parameter int LAST_IDX = DEPTH - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_init,
  input  logic          cfg_irq_en,
  input  logic [7:0]    cfg_cid,
  input  logic [15:0]   cfg_max_len,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_err,
  output logic          buf_we,
  output logic [31:0]   buf_addr,
  output logic [7:0]    buf_wdata,
  output logic          irq,
  output logic [IW-1:0] cur_idx,
  input  logic [6:0]    cur_ctl,
  input  logic [31:0]   cur_bufptr,
  output logic          desc_we,
  output logic [31:0]   desc_word,
  output logic          ev_push,
  output ev_t           ev_data,
  output logic          eng_idle,
  output logic          close_fire,
  output logic          close_err,
  output logic [31:0]   pkt_base
);
  st_e           st;
  logic [IW-1:0] idx;
  logic [7:0]    h0, h1, h2;
  logic [15:0]   cnt;
  logic          err_q, trunc_q;
  logic [31:0]   base;
  logic          accept, room, hdr_fail, wrap_now;
  logic [IW-1:0] idx_next;

  function automatic logic [IW-1:0] advance(input logic [IW-1:0] i, input logic w);
    return (w || i == IW'(LAST_IDX)) ? '0 : i + 1'b1;
  endfunction

  assign in_ready = (st == ST_IDLE) ? cur_ctl[BIT_OWN] : (st != ST_CLOSE);
  assign accept   = in_valid & in_ready;
  assign room     = (cnt < cfg_max_len);

  assign buf_we    = (st == ST_PAY) & accept & room;
  assign buf_addr  = base + {16'h0000, cnt};
  assign buf_wdata = in_data;

  assign hdr_fail   = (st == ST_HB2) & accept & ~hdr_good(h0, h1, in_data);
  assign close_fire = (st == ST_CLOSE);
  assign close_err  = err_q | trunc_q;
  assign desc_we    = close_fire;
  assign desc_word  = close_word(h0, h1, h2, cur_ctl[6:1], close_err);
  assign irq        = close_fire & cur_ctl[BIT_INT] & cfg_irq_en;

  assign wrap_now = cur_ctl[BIT_WRAP];
  assign idx_next = advance(idx, wrap_now);

  // header event and close event never share a cycle
  assign ev_push = hdr_fail | (close_fire & close_err);
  always_comb begin
    if (hdr_fail) begin
      ev_data.code = EV_HDR;
      ev_data.cid  = 8'h00;
    end else begin
      ev_data.code = err_q ? EV_RXERR : EV_TRUNC;
      ev_data.cid  = cfg_cid;
    end
  end

  assign cur_idx  = idx;
  assign eng_idle = (st == ST_IDLE);
  assign pkt_base = base;

  always_ff @(posedge clk) begin
    if (!rst_n || chan_init) begin
      st      <= ST_IDLE;
      idx     <= '0;
      h0      <= '0;
      h1      <= '0;
      h2      <= '0;
      cnt     <= '0;
      err_q   <= 1'b0;
      trunc_q <= 1'b0;
      base    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          h0      <= in_data;
          h1      <= '0;
          h2      <= '0;
          cnt     <= '0;
          trunc_q <= 1'b0;
          base    <= cur_bufptr;
          err_q   <= in_err | in_last;
          st      <= in_last ? ST_CLOSE : ST_HB1;
        end
        ST_HB1: if (accept) begin
          h1    <= in_data;
          err_q <= err_q | in_err | in_last;
          st    <= in_last ? ST_CLOSE : ST_HB2;
        end
        ST_HB2: if (accept) begin
          h2    <= in_data;
          err_q <= err_q | in_err;
          st    <= in_last ? ST_CLOSE : ST_PAY;
        end
        ST_PAY: if (accept) begin
          if (room) cnt <= cnt + 16'd1;
          else      trunc_q <= 1'b1;
          err_q <= err_q | in_err;
          if (in_last) st <= ST_CLOSE;
        end
        ST_CLOSE: begin
          idx <= idx_next;
          st  <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_bd_ring.sv
module rx_bd_ring
  import rxbd_pkg::*;
#(
  parameter  int DESC_DEPTH = 8,
  parameter  int EVQ_DEPTH  = 4,
  localparam int IW         = $clog2(DESC_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_init,
  input  logic          cfg_irq_en,
  input  logic [7:0]    cfg_cid,
  input  logic [15:0]   cfg_max_len,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_err,
  output logic          buf_we,
  output logic [31:0]   buf_addr,
  output logic [7:0]    buf_wdata,
  output logic          irq,
  input  logic          sw_we,
  input  logic [IW:0]   sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic          evq_pop,
  output logic          evq_valid,
  output logic [1:0]    evq_code,
  output logic [7:0]    evq_cid,
  output logic          evq_ovf
);
  localparam int MAX_ENTRIES = TABLE_LIMIT_BYTES / DESC_BYTES;
  localparam int LAST_IDX    = ((DESC_DEPTH < MAX_ENTRIES) ? DESC_DEPTH : MAX_ENTRIES) - 1;

  logic [IW-1:0] cur_idx;
  logic [6:0]    cur_ctl;
  logic [31:0]   cur_bufptr;
  logic          desc_we;
  logic [31:0]   desc_word;
  logic          ev_push;
  ev_t           ev_data;
  ev_t           ev_head;
  logic          eng_idle, close_fire, close_err;
  logic [31:0]   pkt_base;
  logic          cur_own, cur_cont, cur_wrap;

  assign cur_own  = cur_ctl[BIT_OWN];
  assign cur_cont = cur_ctl[BIT_CONT];
  assign cur_wrap = cur_ctl[BIT_WRAP];

  rxbd_table #(.DEPTH(DESC_DEPTH), .IW(IW)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (sw_we),
    .sw_addr   (sw_addr),
    .sw_wdata  (sw_wdata),
    .sw_rdata  (sw_rdata),
    .hw_idx    (cur_idx),
    .hw_ctl    (cur_ctl),
    .hw_bufptr (cur_bufptr),
    .hw_we     (desc_we),
    .hw_word0  (desc_word)
  );

  rxbd_engine #(.DEPTH(DESC_DEPTH), .IW(IW), .LAST_IDX(LAST_IDX)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_init   (chan_init),
    .cfg_irq_en  (cfg_irq_en),
    .cfg_cid     (cfg_cid),
    .cfg_max_len (cfg_max_len),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .in_last     (in_last),
    .in_err      (in_err),
    .buf_we      (buf_we),
    .buf_addr    (buf_addr),
    .buf_wdata   (buf_wdata),
    .irq         (irq),
    .cur_idx     (cur_idx),
    .cur_ctl     (cur_ctl),
    .cur_bufptr  (cur_bufptr),
    .desc_we     (desc_we),
    .desc_word   (desc_word),
    .ev_push     (ev_push),
    .ev_data     (ev_data),
    .eng_idle    (eng_idle),
    .close_fire  (close_fire),
    .close_err   (close_err),
    .pkt_base    (pkt_base)
  );

  rxbd_evq #(.DEPTH(EVQ_DEPTH)) u_evq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (chan_init),
    .push    (ev_push),
    .push_ev (ev_data),
    .pop     (evq_pop),
    .valid   (evq_valid),
    .head    (ev_head),
    .ovf     (evq_ovf)
  );

  assign evq_code = ev_head.code;
  assign evq_cid  = ev_head.cid;
endmodule

// File: rtl/rx_bd_ring_chk.sv
module rx_bd_ring_chk #(
  parameter int IW       = 3,
  parameter int LAST_IDX = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_init,
  input logic          cfg_irq_en,
  input logic [15:0]   cfg_max_len,
  input logic          in_valid,
  input logic          in_ready,
  input logic          irq,
  input logic          buf_we,
  input logic [31:0]   buf_addr,
  input logic          evq_ovf,
  input logic [IW-1:0] cur_idx,
  input logic          cur_own,
  input logic          cur_cont,
  input logic          cur_wrap,
  input logic          eng_idle,
  input logic          close_fire,
  input logic          close_err,
  input logic [31:0]   close_word,
  input logic [31:0]   pkt_base
);
  p_start_owned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle && in_valid && in_ready) |-> cur_own);

  p_cont_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (close_fire && !close_err && cur_cont) |-> close_word[0]);

  p_err_returns_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (close_fire && close_err) |-> (!close_word[0] && close_word[7]));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (close_fire && cur_wrap && !chan_init) |=> (cur_idx == '0));

  p_force_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (close_fire && cur_idx == IW'(LAST_IDX) && !chan_init) |=> (cur_idx == '0));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (close_fire && cfg_irq_en));

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_len_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> ((buf_addr - pkt_base) < {16'h0000, cfg_max_len}));

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (evq_ovf && !chan_init) |=> evq_ovf);

  p_init_r12: assert property (@(posedge clk) disable iff (!rst_n)
    chan_init |=> (eng_idle && cur_idx == '0 && !evq_ovf));
endmodule

bind rx_bd_ring rx_bd_ring_chk #(.IW(IW), .LAST_IDX(LAST_IDX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_init   (chan_init),
  .cfg_irq_en  (cfg_irq_en),
  .cfg_max_len (cfg_max_len),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .irq         (irq),
  .buf_we      (buf_we),
  .buf_addr    (buf_addr),
  .evq_ovf     (evq_ovf),
  .cur_idx     (cur_idx),
  .cur_own     (cur_own),
  .cur_cont    (cur_cont),
  .cur_wrap    (cur_wrap),
  .eng_idle    (eng_idle),
  .close_fire  (close_fire),
  .close_err   (close_err),
  .close_word  (desc_word),
  .pkt_base    (pkt_base)
);

// File: tb/tb_rx_bd_ring.sv
`timescale 1ns/100ps
module tb_rx_bd_ring;
  localparam int DEPTH = 8;
  localparam int MAXL  = 4;
  localparam logic [7:0] CID = 8'h5C;

  logic        clk = 1'b0;
  logic        rst_n, chan_init, cfg_irq_en;
  logic [7:0]  cfg_cid;
  logic [15:0] cfg_max_len;
  logic        in_valid, in_ready, in_last, in_err;
  logic [7:0]  in_data;
  logic        buf_we;
  logic [31:0] buf_addr;
  logic [7:0]  buf_wdata;
  logic        irq;
  logic        sw_we;
  logic [3:0]  sw_addr;
  logic [31:0] sw_wdata, sw_rdata;
  logic        evq_pop, evq_valid, evq_ovf;
  logic [1:0]  evq_code;
  logic [7:0]  evq_cid;

  always #2.5 clk = ~clk;

  rx_bd_ring #(.DESC_DEPTH(DEPTH), .EVQ_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .chan_init(chan_init), .cfg_irq_en(cfg_irq_en),
    .cfg_cid(cfg_cid), .cfg_max_len(cfg_max_len), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last), .in_err(in_err),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .irq(irq),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .evq_pop(evq_pop), .evq_valid(evq_valid), .evq_code(evq_code),
    .evq_cid(evq_cid), .evq_ovf(evq_ovf)
  );

  int checks = 0;
  int fails  = 0;
  logic [2:0]  exp_idx;
  logic [31:0] exp_base;
  int exp_total, wr_seen, seed, irq_cnt;

  function automatic logic [7:0] pat(input int p, input int k);
    return 8'((p * 13) + (k * 7) + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // buffer-write and interrupt monitor, sampled between edges
  always @(negedge clk) begin
    #1;
    if (rst_n && buf_we) begin
      if (wr_seen >= exp_total)
        chk(1'b0, "R10 write beyond limit", 32'(wr_seen), 32'(exp_total));
      else begin
        chk(buf_addr == exp_base + 32'(wr_seen), "R5 address", buf_addr,
            exp_base + 32'(wr_seen));
        chk(buf_wdata == pat(seed, wr_seen), "R5 data", 32'(buf_wdata),
            32'(pat(seed, wr_seen)));
      end
      wr_seen++;
    end
    if (rst_n && irq) irq_cnt++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic sw_wr(input logic [2:0] idx, input bit sel, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_addr = {idx, sel}; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_rd(input logic [2:0] idx, input bit sel, output logic [31:0] d);
    @(negedge clk);
    sw_addr = {idx, sel};
    #0.5;
    d = sw_rdata;
  endtask

  task automatic put_byte(input logic [7:0] d, input bit last, input bit err);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last; in_err = err;
    #0.5;
    while (!in_ready) begin
      @(negedge clk);
      #0.5;
    end
    @(posedge clk);
  endtask

  task automatic pop_ev(input logic [1:0] code, input logic [7:0] cid, input string tag);
    @(negedge clk);
    #0.5;
    chk(evq_valid == 1'b1, tag, 32'(evq_valid), 32'd1);
    chk({evq_code, evq_cid} == {code, cid}, tag, 32'({evq_code, evq_cid}),
        32'({code, cid}));
    evq_pop = 1'b1;
    @(negedge clk);
    evq_pop = 1'b0;
  endtask

  task automatic run_pkt(input int p, input bit cm, input bit ii, input bit w,
                         input bit err, input int len, input bit bad, input bit en,
                         input bit drain, input string tag);
    logic [31:0] w0, bp, got, expw;
    logic [7:0]  h0, h1, h2;
    bit trunc, badc;
    cfg_irq_en = en;
    w0 = {24'h0, 4'b0000, ii, w, cm, 1'b1};
    bp = 32'h0001_0000 + 32'(p) * 32'h100;
    sw_wr(exp_idx, 1'b0, w0);
    sw_wr(exp_idx, 1'b1, bp);
    h0 = 8'((p * 5) + 1);
    h1 = 8'hA0 ^ 8'(p);
    h2 = bad ? ~(h0 ^ h1) : (h0 ^ h1);
    exp_base = bp; exp_total = (len < MAXL) ? len : MAXL;
    wr_seen = 0; seed = p; irq_cnt = 0;
    put_byte(h0, 1'b0, 1'b0);
    put_byte(h1, 1'b0, 1'b0);
    put_byte(h2, len == 0, err && len == 0);
    for (int k = 0; k < len; k++) put_byte(pat(p, k), k == len - 1, err && k == len - 1);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    repeat (3) @(negedge clk);
    trunc = (len > MAXL);
    badc  = err | trunc;
    expw  = {h1, h2, h0, badc, 3'b000, ii, w, cm, cm & ~badc};
    sw_rd(exp_idx, 1'b0, got);
    chk(got == expw, tag, got, expw);
    sw_rd(exp_idx, 1'b1, got);
    chk(got == bp, "R2 pointer untouched", got, bp);
    chk(wr_seen == exp_total, "R10 stored byte count", 32'(wr_seen), 32'(exp_total));
    chk(irq_cnt == int'(ii & en), "R8 interrupt gating", 32'(irq_cnt), 32'(ii & en));
    if (drain) begin
      if (bad) pop_ev(2'd3, 8'h00, "R9 header event");
      if (err) pop_ev(2'd1, CID, "R4 error event");
      else if (trunc) pop_ev(2'd2, CID, "R10 length event");
      @(negedge clk);
      #0.5;
      chk(evq_valid == 1'b0, "R11 queue drained", 32'(evq_valid), 32'd0);
    end
    exp_idx = (w || exp_idx == 3'(DEPTH - 1)) ? 3'd0 : exp_idx + 3'd1;
  endtask

  initial begin
    logic [31:0] got;
    string tag;
    bit prev_w, prev_last;
    rst_n = 1'b0; chan_init = 1'b0; cfg_irq_en = 1'b0; cfg_cid = CID;
    cfg_max_len = 16'(MAXL); in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    in_err = 1'b0; sw_we = 1'b0; sw_addr = '0; sw_wdata = '0; evq_pop = 1'b0;
    exp_idx = '0; exp_total = 0; wr_seen = 0; seed = 0; irq_cnt = 0; exp_base = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #0.5;
    chk(in_ready == 1'b0, "R1 reset not ready", 32'(in_ready), 32'd0);
    chk(irq == 1'b0, "R8 reset irq", 32'(irq), 32'd0);
    chk(evq_valid == 1'b0, "R11 reset queue empty", 32'(evq_valid), 32'd0);
    chk(evq_ovf == 1'b0, "R11 reset ovf", 32'(evq_ovf), 32'd0);
    sw_rd(3'd0, 1'b0, got);
    chk(got == 32'h0, "R2 reset word0", got, 32'h0);

    // R1: software-owned descriptor stalls the channel
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h11; in_last = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      #0.5;
      chk(in_ready == 1'b0, "R1 stall ready", 32'(in_ready), 32'd0);
      chk(buf_we == 1'b0, "R1 stall write", 32'(buf_we), 32'd0);
    end
    in_valid = 1'b0; in_last = 1'b0;
    sw_rd(3'd0, 1'b0, got);
    chk(got == 32'h0, "R1 descriptor untouched", got, 32'h0);

    // sweep over flag combinations, lengths, errors and ring positions
    prev_w = 1'b0; prev_last = 1'b0;
    for (int p = 0; p < 24; p++) begin
      bit cm, ii, en, w, err, bad;
      int len;
      cm = p[0]; ii = p[1]; en = p[2];
      w = (p % 11 == 10); err = (p % 7 == 6); len = p % 6; bad = (p % 4 == 3);
      if (prev_w)               tag = "R6 wrap target word0";
      else if (prev_last)       tag = "R7 forced wrap word0";
      else if (err)             tag = "R4 error close word0";
      else if (len > MAXL)      tag = "R10 truncated close word0";
      else if (cm)              tag = "R3 continuous close word0";
      else                      tag = "R2 normal close word0";
      prev_last = (exp_idx == 3'(DEPTH - 1)) && !w;
      prev_w = w;
      run_pkt(p, cm, ii, w, err, len, bad, en, 1'b1, tag);
    end

    // R4: packet ending inside the header
    sw_wr(exp_idx, 1'b0, 32'h0000_0003);
    sw_wr(exp_idx, 1'b1, 32'h0002_0000);
    exp_total = 0; wr_seen = 0;
    put_byte(8'h42, 1'b0, 1'b0);
    put_byte(8'h43, 1'b1, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    sw_rd(exp_idx, 1'b0, got);
    chk((got & 32'h0000_FF81) == 32'h0000_4280, "R4 short packet word0",
        got & 32'h0000_FF81, 32'h0000_4280);
    pop_ev(2'd1, CID, "R4 short packet event");
    exp_idx = (exp_idx == 3'(DEPTH - 1)) ? 3'd0 : exp_idx + 3'd1;

    // R11: overflow of the event queue
    for (int q = 0; q < 5; q++) run_pkt(40 + q, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b0,
                                        1'b0, "R11 overflow packet word0");
    @(negedge clk);
    #0.5;
    chk(evq_ovf == 1'b1, "R11 ovf set", 32'(evq_ovf), 32'd1);
    for (int q = 0; q < 4; q++) pop_ev(2'd3, 8'h00, "R11 kept entry");
    @(negedge clk);
    #0.5;
    chk(evq_valid == 1'b0, "R11 dropped entry absent", 32'(evq_valid), 32'd0);
    chk(evq_ovf == 1'b1, "R11 ovf held", 32'(evq_ovf), 32'd1);

    // R12: channel init returns to descriptor 0
    if (exp_idx == 3'd0)
      run_pkt(60, 1'b0, 1'b0, 1'b0, 1'b0, 2, 1'b0, 1'b0, 1'b1, "R2 normal close word0");
    @(negedge clk);
    chan_init = 1'b1;
    @(negedge clk);
    chan_init = 1'b0;
    #0.5;
    chk(evq_ovf == 1'b0, "R12 ovf cleared", 32'(evq_ovf), 32'd0);
    exp_idx = 3'd0;
    run_pkt(61, 1'b0, 1'b1, 1'b0, 1'b0, 3, 1'b0, 1'b1, 1'b1, "R12 restart word0");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule